// File: doc/BRIEF.md
# Bit-Timing Loop Bandwidth Sequencer

This block picks the bandwidth code that the receive bit-timing recovery loop uses. Most of the time the loop runs at a normal bandwidth set by a control field. A command write that asks for clock acquisition switches the loop to its widest setting, so it can lock on quickly. The block then lowers the bandwidth one step at a time, counting received bit ticks, until it reaches the normal setting. It then reports that the acquisition is complete.

The host sends acquisition requests as part of ordinary command writes. A request is ignored in transmit mode, and it is also ignored when the same byte carries the reset task. A write without the request leaves a running sequence alone. A write with the request starts the sequence again from the widest setting. With the default schedule the sequence takes at most 12 bit ticks. It can therefore be issued a few bits ahead of a frame-sync search. All pins are plain control and status signals, with no handshake.

Top module: `bitclk_acq_seq`

## Requirements
- R1: A qualifying command write starts a sequence. A write qualifies when `cmd_wr`=1, `cmd_acq`=1, `tx_mode`=0 and `cmd_task`≠3'b000. In the next cycle `acq_busy`=1, `acq_done`=0 and `bw_code`=3, the widest code.
- R2: A write with `cmd_acq`=1 has no effect while `tx_mode`=1. No sequence starts.
- R3: A write with `cmd_acq`=1 has no effect when `cmd_task`=3'b000, the reset task. No sequence starts.
- R4: A command write with `cmd_acq`=0 does not alter a running sequence. The code is unchanged and the bit-tick count is not reset.
- R5: A qualifying write during a running sequence restarts it. The code goes back to 3 and the bit-tick count goes back to zero.
- R6: While busy, the code drops by one on every 4th `bit_tick`. Cycles without a tick leave the count and the code unchanged.
- R7: The sequence ends on the tick where the code reaches `normal_bw`. On that tick `acq_busy` falls and `acq_done` rises. When the block is not busy, `bw_code` equals `normal_bw`.
- R8: If `normal_bw`=3, the sequence ends on the first `bit_tick`.
- R9: Whenever `tx_mode`=1, the next cycle has `acq_busy`=0 and `acq_done`=0. A running sequence is abandoned.
- R10: After reset, `acq_busy`=0, `acq_done`=0 and `bw_code` follows `normal_bw`.
- R11: If a qualifying write and a `bit_tick` arrive in the same cycle, the write wins. That tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_acq | input | 1 | Acquire-clock request bit of the written byte |
| cmd_task | input | 3 | Task field of the written byte; 3'b000 is the reset task |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| bit_tick | input | 1 | One pulse per received bit period |
| normal_bw | input | 2 | Normal loop bandwidth code; 3 is the widest |
| bw_code | output | 2 | Bandwidth code applied to the timing loop |
| acq_busy | output | 1 | Acquisition sequence running |
| acq_done | output | 1 | Last sequence reached the normal code |

## Verification
A wrong tick count shows on `bw_code`. The step down comes one tick early or one tick late, and the error is visible no later than the fourth tick after it occurs. A wrong phase shows in the next cycle. Either `acq_busy` and `acq_done` take the wrong values, or `bw_code` keeps a stale step where it should follow `normal_bw`. The reference model is compared on every clock, so each of these errors is reported in the cycle where it first appears.

// File: rtl/bca_pkg.sv
package bca_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } seq_phase_t;
endpackage

// File: rtl/bca_trigger.sv
module bca_trigger #(
  parameter int TASK_W = 3,
  parameter logic [TASK_W-1:0] RESET_TASK = '0
) (
  input  logic              cmd_wr,
  input  logic              cmd_acq,
  input  logic [TASK_W-1:0] cmd_task,
  input  logic              tx_mode,
  output logic              start
);
  // Only receive-mode writes that request acquisition and are not a reset task qualify
  always_comb start = cmd_wr && cmd_acq && !tx_mode && (cmd_task != RESET_TASK);
endmodule

// File: rtl/bca_step_timer.sv
module bca_step_timer #(
  parameter int TICKS_PER_STEP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic step
);
  localparam int CNT_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_STEP - 1);

  logic [CNT_W-1:0] cnt_q;

  always_comb step = tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (step)     cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + CNT_W'(1);
  end

  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(cnt_q));
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/bca_gear.sv
module bca_gear
  import bca_pkg::*;
#(
  parameter int BW_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic            tick,
  input  logic            step,
  input  logic [BW_W-1:0] normal_bw,
  output logic [BW_W-1:0] bw_q,
  output seq_phase_t      phase_q
);
  localparam logic [BW_W-1:0] WIDEST = {BW_W{1'b1}};

  logic [BW_W-1:0] bw_less;
  always_comb bw_less = bw_q - BW_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bw_q    <= WIDEST;
    end else if (start) begin
      phase_q <= PH_RUN;
      bw_q    <= WIDEST;
    end else if (abort) begin
      phase_q <= PH_IDLE;
    end else if (phase_q == PH_RUN && tick) begin
      if (bw_q <= normal_bw) begin
        phase_q <= PH_DONE;
      end else if (step) begin
        bw_q <= bw_less;
        if (bw_less <= normal_bw) phase_q <= PH_DONE;
      end
    end
  end

  p_only_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && !start) |=> (bw_q <= $past(bw_q)));
  p_start_widest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase_q == PH_RUN && bw_q == WIDEST));
endmodule

// File: rtl/bitclk_acq_seq.sv
module bitclk_acq_seq
  import bca_pkg::*;
#(
  parameter int BW_W           = 2,
  parameter int TASK_W         = 3,
  parameter int TICKS_PER_STEP = 4,
  parameter logic [TASK_W-1:0] RESET_TASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_acq,
  input  logic [TASK_W-1:0] cmd_task,
  input  logic              tx_mode,
  input  logic              bit_tick,
  input  logic [BW_W-1:0]   normal_bw,
  output logic [BW_W-1:0]   bw_code,
  output logic              acq_busy,
  output logic              acq_done
);
  localparam logic [BW_W-1:0] WIDEST = {BW_W{1'b1}};

  logic            start;
  logic            step;
  logic [BW_W-1:0] bw_q;
  seq_phase_t      phase_q;

  bca_trigger #(.TASK_W(TASK_W), .RESET_TASK(RESET_TASK)) u_trig (
    .cmd_wr(cmd_wr), .cmd_acq(cmd_acq), .cmd_task(cmd_task),
    .tx_mode(tx_mode), .start(start)
  );

  bca_step_timer #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clear(start || (phase_q != PH_RUN)),
    .tick(bit_tick), .step(step)
  );

  bca_gear #(.BW_W(BW_W)) u_gear (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(tx_mode),
    .tick(bit_tick), .step(step), .normal_bw(normal_bw),
    .bw_q(bw_q), .phase_q(phase_q)
  );

  always_comb begin
    acq_busy = (phase_q == PH_RUN);
    acq_done = (phase_q == PH_DONE);
    bw_code  = acq_busy ? bw_q : normal_bw;
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_acq && !tx_mode && cmd_task != RESET_TASK)
      |=> (acq_busy && !acq_done && bw_code == WIDEST));
  p_tx_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && tx_mode && !acq_busy) |=> !acq_busy);
  p_reset_task_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_task == RESET_TASK && !acq_busy) |=> !acq_busy);
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode |=> (!acq_busy && !acq_done));
  p_done_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_done) |-> $past(bit_tick));
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_busy && acq_done));
endmodule

// File: tb/bitclk_acq_seq_test.sv
module bitclk_acq_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0, cmd_acq = 1'b0, tx_mode = 1'b0, bit_tick = 1'b0;
  logic [2:0] cmd_task = 3'b010;
  logic [1:0] normal_bw = 2'd2;
  logic [1:0] bw_code;
  logic       acq_busy, acq_done;

  bitclk_acq_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_acq(cmd_acq),
    .cmd_task(cmd_task), .tx_mode(tx_mode), .bit_tick(bit_tick),
    .normal_bw(normal_bw), .bw_code(bw_code), .acq_busy(acq_busy),
    .acq_done(acq_done)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R10";
  bit    over = 1'b0;
  int    m_busy = 0, m_done = 0, m_bw = 3, m_ticks = 0;

  task automatic model_step;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_bw = 3; m_ticks = 0;
    end else if (cmd_wr && cmd_acq && !tx_mode && cmd_task != 3'b000) begin
      m_busy = 1; m_done = 0; m_bw = 3; m_ticks = 0;
    end else if (tx_mode) begin
      m_busy = 0; m_done = 0; m_ticks = 0;
    end else if (m_busy == 1 && bit_tick) begin
      if (m_bw <= int'(normal_bw)) begin
        m_busy = 0; m_done = 1;
      end else begin
        m_ticks++;
        if (m_ticks == 4) begin
          m_ticks = 0;
          m_bw--;
          if (m_bw <= int'(normal_bw)) begin m_busy = 0; m_done = 1; end
        end
      end
    end
  endtask

  task automatic compare;
    int exp_bw;
    exp_bw = m_busy ? m_bw : int'(normal_bw);
    checks++;
    if (int'(bw_code) != exp_bw || int'(acq_busy) != m_busy || int'(acq_done) != m_done) begin
      fails++;
      $display("FAIL %s: bw=%0d busy=%0d done=%0d expected bw=%0d busy=%0d done=%0d",
               cur_req, bw_code, acq_busy, acq_done, exp_bw, m_busy, m_done);
    end
  endtask

  task automatic expect_state(string r, int b, int d, int bw);
    checks++;
    if (int'(acq_busy) != b || int'(acq_done) != d || int'(bw_code) != bw) begin
      fails++;
      $display("FAIL %s: bw=%0d busy=%0d done=%0d expected bw=%0d busy=%0d done=%0d",
               r, bw_code, acq_busy, acq_done, bw, b, d);
    end
  endtask

  task automatic one;
    @(posedge clk);
    model_step();
    #1;
    compare();
  endtask

  task automatic idle(int n);
    repeat (n) one();
  endtask

  task automatic write(bit acq, logic [2:0] t, bit tk);
    cmd_wr = 1'b1; cmd_acq = acq; cmd_task = t; bit_tick = tk;
    one();
    cmd_wr = 1'b0; cmd_acq = 1'b0; bit_tick = 1'b0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      one();
      bit_tick = 1'b0;
      repeat (gap) one();
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!over) begin
      fails++;
      $display("FAIL watchdog: run still going, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(2);
    expect_state("R10", 0, 0, 2);
    rst_n = 1'b1;
    idle(2);
    expect_state("R10", 0, 0, 2);

    cur_req = "R1"; normal_bw = 2'd1;
    write(1, 3'b010, 0);
    expect_state("R1", 1, 0, 3);
    cur_req = "R6";
    ticks(3, 2);
    expect_state("R6", 1, 0, 3);
    ticks(1, 2);
    expect_state("R6", 1, 0, 2);
    cur_req = "R7";
    ticks(4, 0);
    expect_state("R7", 0, 1, 1);
    normal_bw = 2'd2;
    one();
    expect_state("R7", 0, 1, 2);

    normal_bw = 2'd0;
    write(1, 3'b101, 0);
    ticks(11, 0);
    expect_state("R6", 1, 0, 1);
    ticks(1, 0);
    expect_state("R7", 0, 1, 0);

    cur_req = "R8"; normal_bw = 2'd3;
    write(1, 3'b010, 0);
    idle(3);
    expect_state("R8", 1, 0, 3);
    ticks(1, 1);
    expect_state("R8", 0, 1, 3);

    cur_req = "R2"; tx_mode = 1'b1;
    write(1, 3'b010, 0);
    expect_state("R2", 0, 0, 3);
    tx_mode = 1'b0;
    idle(2);
    expect_state("R2", 0, 0, 3);

    cur_req = "R3"; normal_bw = 2'd0;
    write(1, 3'b000, 0);
    idle(1);
    expect_state("R3", 0, 0, 0);

    cur_req = "R4";
    write(1, 3'b010, 0);
    ticks(5, 0);
    write(0, 3'b011, 0);
    expect_state("R4", 1, 0, 2);
    ticks(3, 0);
    expect_state("R4", 1, 0, 1);

    cur_req = "R5";
    ticks(2, 0);
    write(1, 3'b010, 0);
    expect_state("R5", 1, 0, 3);
    ticks(3, 0);
    expect_state("R5", 1, 0, 3);
    ticks(1, 0);
    expect_state("R5", 1, 0, 2);

    cur_req = "R9"; tx_mode = 1'b1;
    one();
    expect_state("R9", 0, 0, 0);
    tx_mode = 1'b0;
    ticks(2, 0);
    expect_state("R9", 0, 0, 0);

    cur_req = "R11";
    write(1, 3'b010, 1);
    expect_state("R11", 1, 0, 3);
    ticks(3, 0);
    expect_state("R11", 1, 0, 3);
    ticks(1, 0);
    expect_state("R11", 1, 0, 2);
    ticks(8, 1);
    expect_state("R7", 0, 1, 0);

    over = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule